// File: doc/BRIEF.md
# Address-Space-Tagged Translation Lookaside Buffer

This block translates 32-bit virtual addresses into physical addresses. It holds 64 translations in a fully associative store. Every entry carries a 6-bit address-space tag, so translations from different processes can sit in the store side by side. A context switch changes the identifier presented with each lookup and needs no flush.

The top three bits of the address choose one of four fixed regions. Two kernel regions bypass the store with a direct mapping: one is marked cacheable and the other uncacheable. The user region and the upper kernel region are translated through the store. A lookup returns its result one cycle later. The result is one of four outcomes: a translation with its attributes, a miss, a protection fault, or an address error.

On a miss, software refills an entry through the write port. It can take the slot from a free-running replacement index that the block provides. Software can invalidate a single entry, or clear every entry in one cycle.

Top module: `tlb_asid_xlate`

## Requirements
- R1: Address bits [31:29] select the region. Patterns 0xx (user) and 11x (upper kernel) are translated through the store. Pattern 100 is a direct cacheable kernel region. Pattern 101 is a direct uncacheable kernel region.
- R2: A kernel-mode lookup in a direct region returns a hit with physical address {3'b000, va[28:0]}, dirty 0, referenced 0 and writable 1. Cacheable is 1 for pattern 100 and 0 for pattern 101.
- R3: A lookup in a translated region hits only on an entry whose valid bit is set and whose page number (va[31:12]) and identifier both match. It returns physical address {frame, va[11:0]}, cacheable 1, and the entry's dirty, referenced and writable flags.
- R4: A translated lookup that matches no entry returns miss, with a physical address of zero and all attributes zero.
- R5: A store (lk_store=1) that matches an entry whose writable flag is 0 returns a protection fault and no translation. A load to the same entry hits.
- R6: A user-mode lookup (lk_user_mode=1) with va[31]=1 returns an address error, whatever the store holds.
- R7: Every lookup request produces a response in the following cycle. While rsp_valid is high, exactly one of hit, miss, protection fault and address error is set. While it is low, none of them is set.
- R8: A write stores the page number, identifier, frame and the dirty, referenced, valid and writable flags at wr_idx. A lookup issued in the same cycle as the write sees the old contents. A lookup issued one cycle later sees the new entry.
- R9: An invalidate clears the valid bit of entry inv_idx and leaves the other entries alone. It takes precedence over a write to the same slot in the same cycle.
- R10: A global flush clears every valid bit in one cycle and takes precedence over a write or invalidate in the same cycle.
- R11: The replacement index rand_idx is 0 during reset. After reset it increases by one each cycle and wraps from 63 to 0.
- R12: After reset no entry is valid, so every translated lookup misses.
- R13: If several valid entries match, the entry with the lowest index supplies the translation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_req | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_asid | input | 6 | Address-space identifier of the access |
| lk_store | input | 1 | Access is a store |
| lk_user_mode | input | 1 | Access is made in user mode |
| wr_en | input | 1 | Write an entry |
| wr_idx | input | 6 | Slot to write |
| wr_vpn | input | 20 | Virtual page number tag |
| wr_asid | input | 6 | Identifier tag |
| wr_pfn | input | 20 | Physical frame number |
| wr_dirty | input | 1 | Dirty flag |
| wr_ref | input | 1 | Referenced flag |
| wr_valid | input | 1 | Valid flag |
| wr_writable | input | 1 | Read/write (1) or read-only (0) |
| inv_en | input | 1 | Invalidate one entry |
| inv_idx | input | 6 | Slot to invalidate |
| flush_all | input | 1 | Clear all valid bits |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Translation returned |
| rsp_miss | output | 1 | No matching entry |
| rsp_prot_fault | output | 1 | Store to a read-only entry |
| rsp_addr_err | output | 1 | User access to a kernel region |
| rsp_paddr | output | 32 | Physical address |
| rsp_cacheable | output | 1 | Access may be cached |
| rsp_dirty | output | 1 | Entry dirty flag |
| rsp_referenced | output | 1 | Entry referenced flag |
| rsp_writable | output | 1 | Entry writable flag |
| rand_idx | output | 6 | Free-running replacement slot |

## Verification
The hardest cases to reach from the ports are the collisions on the store. These are a lookup issued in the same cycle as the write that would satisfy it, an invalidate and a write aimed at the same slot, a flush that coincides with a write, and two valid entries with the same tag. The stimulus reaches them by driving the write, invalidate and flush inputs together with a lookup on a single clock edge. It then follows with lookups whose expected outcome shows which action won. To place duplicate tags, it writes a higher slot first and a lower slot second, then invalidates the lower slot so that the higher one becomes visible.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    localparam int VA_W       = 32;
    localparam int PAGE_OFS_W = 12;
    localparam int VPN_W      = VA_W - PAGE_OFS_W;
    localparam int PFN_W      = 20;
    localparam int PA_W       = PFN_W + PAGE_OFS_W;
    localparam int ASID_W     = 6;
    localparam int N_ENTRIES  = 64;
    localparam int IDX_W      = $clog2(N_ENTRIES);
    localparam int RGN_W      = 3;

    typedef enum logic [1:0] {
        RGN_USER_MAP,
        RGN_KERN_CACHED,
        RGN_KERN_UNCACHED,
        RGN_KERN_MAP
    } region_e;

    // Fields that a hit hands back to the requester.
    typedef struct packed {
        logic [PFN_W-1:0] pfn;
        logic             dirty;
        logic             refd;
        logic             writable;
    } tlb_data_t;

    typedef struct packed {
        logic [VPN_W-1:0]  vpn;
        logic [ASID_W-1:0] asid;
        logic              valid;
        tlb_data_t         data;
    } tlb_entry_t;

    typedef struct packed {
        logic            valid;
        logic            hit;
        logic            miss;
        logic            prot;
        logic            aerr;
        logic [PA_W-1:0] paddr;
        logic            cacheable;
        logic            dirty;
        logic            refd;
        logic            writable;
    } tlb_rsp_t;

    function automatic region_e decode_region(input logic [RGN_W-1:0] top);
        region_e r;
        casez (top)
            3'b0??:  r = RGN_USER_MAP;
            3'b100:  r = RGN_KERN_CACHED;
            3'b101:  r = RGN_KERN_UNCACHED;
            default: r = RGN_KERN_MAP;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/tlb_region_dec.sv
module tlb_region_dec
    import tlb_pkg::*;
(
    input  logic [VA_W-1:0] vaddr,
    input  logic            user_mode,
    output region_e         region,
    output logic            mapped,
    output logic            addr_err,
    output logic [PA_W-1:0] direct_paddr,
    output logic            direct_cacheable
);
    always_comb begin
        region           = decode_region(vaddr[VA_W-1 -: RGN_W]);
        mapped           = (region == RGN_USER_MAP) || (region == RGN_KERN_MAP);
        addr_err         = user_mode && (region != RGN_USER_MAP);
        direct_paddr     = {{RGN_W{1'b0}}, vaddr[VA_W-RGN_W-1:0]};
        direct_cacheable = (region == RGN_KERN_CACHED);
    end
endmodule

// File: rtl/tlb_entry_store.sv
module tlb_entry_store
    import tlb_pkg::*;
#(
    parameter int ENTRIES = N_ENTRIES,
    localparam int IW     = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [IW-1:0]     wr_idx,
    input  tlb_entry_t        wr_entry,
    input  logic              inv_en,
    input  logic [IW-1:0]     inv_idx,
    input  logic              flush_all,
    input  logic [VPN_W-1:0]  lk_vpn,
    input  logic [ASID_W-1:0] lk_asid,
    output logic [ENTRIES-1:0] match_vec,
    output tlb_data_t         data_arr [ENTRIES]
);
    tlb_entry_t ent_q [ENTRIES];

    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                ent_q[g] <= '0;
            end else if (flush_all) begin
                ent_q[g].valid <= 1'b0;
            end else if (inv_en && inv_idx == IW'(g)) begin
                ent_q[g].valid <= 1'b0;
            end else if (wr_en && wr_idx == IW'(g)) begin
                ent_q[g] <= wr_entry;
            end
        end

        assign match_vec[g] = ent_q[g].valid
                           && (ent_q[g].vpn  == lk_vpn)
                           && (ent_q[g].asid == lk_asid);
        assign data_arr[g]  = ent_q[g].data;
    end
endmodule

// File: rtl/tlb_hit_select.sv
module tlb_hit_select
    import tlb_pkg::*;
#(
    parameter int ENTRIES = N_ENTRIES
) (
    input  logic [ENTRIES-1:0] match_vec,
    input  tlb_data_t          data_arr [ENTRIES],
    output logic               any_hit,
    output tlb_data_t          sel_data
);
    // Walk downward so the lowest matching slot is the last one written.
    always_comb begin
        any_hit  = 1'b0;
        sel_data = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (match_vec[i]) begin
                any_hit  = 1'b1;
                sel_data = data_arr[i];
            end
        end
    end
endmodule

// File: rtl/tlb_repl_ctr.sv
module tlb_repl_ctr #(
    parameter int ENTRIES = 64,
    localparam int IW     = $clog2(ENTRIES)
) (
    input  logic          clk,
    input  logic          rst,
    output logic [IW-1:0] idx
);
    always_ff @(posedge clk) begin
        if (rst) begin
            idx <= '0;
        end else if (idx == IW'(ENTRIES - 1)) begin
            idx <= '0;
        end else begin
            idx <= idx + 1'b1;
        end
    end
endmodule

// File: rtl/tlb_asid_xlate.sv
module tlb_asid_xlate
    import tlb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              lk_req,
    input  logic [VA_W-1:0]   lk_vaddr,
    input  logic [ASID_W-1:0] lk_asid,
    input  logic              lk_store,
    input  logic              lk_user_mode,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [VPN_W-1:0]  wr_vpn,
    input  logic [ASID_W-1:0] wr_asid,
    input  logic [PFN_W-1:0]  wr_pfn,
    input  logic              wr_dirty,
    input  logic              wr_ref,
    input  logic              wr_valid,
    input  logic              wr_writable,
    input  logic              inv_en,
    input  logic [IDX_W-1:0]  inv_idx,
    input  logic              flush_all,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic              rsp_miss,
    output logic              rsp_prot_fault,
    output logic              rsp_addr_err,
    output logic [PA_W-1:0]   rsp_paddr,
    output logic              rsp_cacheable,
    output logic              rsp_dirty,
    output logic              rsp_referenced,
    output logic              rsp_writable,
    output logic [IDX_W-1:0]  rand_idx
);
    region_e          region;
    logic             mapped;
    logic             addr_err;
    logic [PA_W-1:0]  direct_paddr;
    logic             direct_cacheable;

    tlb_region_dec u_dec (
        .vaddr            (lk_vaddr),
        .user_mode        (lk_user_mode),
        .region           (region),
        .mapped           (mapped),
        .addr_err         (addr_err),
        .direct_paddr     (direct_paddr),
        .direct_cacheable (direct_cacheable)
    );

    tlb_entry_t             wr_entry;
    logic [N_ENTRIES-1:0]   match_vec;
    tlb_data_t              data_arr [N_ENTRIES];

    always_comb begin
        wr_entry.vpn           = wr_vpn;
        wr_entry.asid          = wr_asid;
        wr_entry.valid         = wr_valid;
        wr_entry.data.pfn      = wr_pfn;
        wr_entry.data.dirty    = wr_dirty;
        wr_entry.data.refd     = wr_ref;
        wr_entry.data.writable = wr_writable;
    end

    tlb_entry_store #(.ENTRIES(N_ENTRIES)) u_store (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_entry  (wr_entry),
        .inv_en    (inv_en),
        .inv_idx   (inv_idx),
        .flush_all (flush_all),
        .lk_vpn    (lk_vaddr[VA_W-1:PAGE_OFS_W]),
        .lk_asid   (lk_asid),
        .match_vec (match_vec),
        .data_arr  (data_arr)
    );

    logic      any_hit;
    tlb_data_t sel_data;

    tlb_hit_select #(.ENTRIES(N_ENTRIES)) u_sel (
        .match_vec (match_vec),
        .data_arr  (data_arr),
        .any_hit   (any_hit),
        .sel_data  (sel_data)
    );

    tlb_repl_ctr #(.ENTRIES(N_ENTRIES)) u_repl (
        .clk (clk),
        .rst (rst),
        .idx (rand_idx)
    );

    // Outcome priority: address error, direct region, miss, protection, hit.
    tlb_rsp_t rsp_d, rsp_q;

    always_comb begin
        rsp_d       = '0;
        rsp_d.valid = lk_req;
        if (lk_req) begin
            if (addr_err) begin
                rsp_d.aerr = 1'b1;
            end else if (!mapped) begin
                rsp_d.hit       = 1'b1;
                rsp_d.paddr     = direct_paddr;
                rsp_d.cacheable = direct_cacheable;
                rsp_d.writable  = 1'b1;
            end else if (!any_hit) begin
                rsp_d.miss = 1'b1;
            end else if (lk_store && !sel_data.writable) begin
                rsp_d.prot = 1'b1;
            end else begin
                rsp_d.hit       = 1'b1;
                rsp_d.paddr     = {sel_data.pfn, lk_vaddr[PAGE_OFS_W-1:0]};
                rsp_d.cacheable = 1'b1;
                rsp_d.dirty     = sel_data.dirty;
                rsp_d.refd      = sel_data.refd;
                rsp_d.writable  = sel_data.writable;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) rsp_q <= '0;
        else     rsp_q <= rsp_d;
    end

    assign rsp_valid      = rsp_q.valid;
    assign rsp_hit        = rsp_q.hit;
    assign rsp_miss       = rsp_q.miss;
    assign rsp_prot_fault = rsp_q.prot;
    assign rsp_addr_err   = rsp_q.aerr;
    assign rsp_paddr      = rsp_q.paddr;
    assign rsp_cacheable  = rsp_q.cacheable;
    assign rsp_dirty      = rsp_q.dirty;
    assign rsp_referenced = rsp_q.refd;
    assign rsp_writable   = rsp_q.writable;
endmodule

// File: rtl/tlb_asid_xlate_chk.sv
module tlb_asid_xlate_chk
    import tlb_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              lk_req,
    input logic [VA_W-1:0]   lk_vaddr,
    input logic              lk_user_mode,
    input logic              rsp_valid,
    input logic              rsp_hit,
    input logic              rsp_miss,
    input logic              rsp_prot_fault,
    input logic              rsp_addr_err,
    input logic [PA_W-1:0]   rsp_paddr,
    input logic              rsp_cacheable,
    input logic [IDX_W-1:0]  rand_idx
);
    AST_RSP_NEXT_CYCLE: assert property (@(posedge clk) disable iff (rst)
        lk_req |=> rsp_valid); // R7

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !rsp_valid |-> !(rsp_hit || rsp_miss || rsp_prot_fault || rsp_addr_err)); // R7

    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $countones({rsp_hit, rsp_miss, rsp_prot_fault, rsp_addr_err}) == 1); // R7

    AST_DIRECT_PADDR: assert property (@(posedge clk) disable iff (rst)
        (lk_req && !lk_user_mode && lk_vaddr[31:30] == 2'b10)
        |=> (rsp_hit && rsp_paddr == {3'b000, $past(lk_vaddr[28:0])})); // R2

    AST_UNCACHED_ATTR: assert property (@(posedge clk) disable iff (rst)
        (lk_req && !lk_user_mode && lk_vaddr[31:29] == 3'b101) |=> !rsp_cacheable); // R2

    AST_USER_KERNEL_ERR: assert property (@(posedge clk) disable iff (rst)
        (lk_req && lk_user_mode && lk_vaddr[31]) |=> rsp_addr_err); // R6

    AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (rst)
        lk_req |=> (!rsp_hit || rsp_paddr[PAGE_OFS_W-1:0] == $past(lk_vaddr[PAGE_OFS_W-1:0]))); // R3

    AST_REPL_STEP: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> rand_idx == IDX_W'($past(rand_idx) + 1'b1)); // R11
endmodule

bind tlb_asid_xlate tlb_asid_xlate_chk u_chk (
    .clk            (clk),
    .rst            (rst),
    .lk_req         (lk_req),
    .lk_vaddr       (lk_vaddr),
    .lk_user_mode   (lk_user_mode),
    .rsp_valid      (rsp_valid),
    .rsp_hit        (rsp_hit),
    .rsp_miss       (rsp_miss),
    .rsp_prot_fault (rsp_prot_fault),
    .rsp_addr_err   (rsp_addr_err),
    .rsp_paddr      (rsp_paddr),
    .rsp_cacheable  (rsp_cacheable),
    .rand_idx       (rand_idx)
);

// File: tb/tlb_asid_xlate_test.sv
module tlb_asid_xlate_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        lk_req = 1'b0;
    logic [31:0] lk_vaddr = '0;
    logic [5:0]  lk_asid = '0;
    logic        lk_store = 1'b0;
    logic        lk_user_mode = 1'b0;
    logic        wr_en = 1'b0;
    logic [5:0]  wr_idx = '0;
    logic [19:0] wr_vpn = '0;
    logic [5:0]  wr_asid = '0;
    logic [19:0] wr_pfn = '0;
    logic        wr_dirty = 1'b0, wr_ref = 1'b0, wr_valid = 1'b0, wr_writable = 1'b0;
    logic        inv_en = 1'b0;
    logic [5:0]  inv_idx = '0;
    logic        flush_all = 1'b0;
    logic        rsp_valid, rsp_hit, rsp_miss, rsp_prot_fault, rsp_addr_err;
    logic [31:0] rsp_paddr;
    logic        rsp_cacheable, rsp_dirty, rsp_referenced, rsp_writable;
    logic [5:0]  rand_idx;

    always #4 clk = ~clk; // 125 MHz

    tlb_asid_xlate uut (.*);

    typedef struct packed {
        logic        hit, miss, prot, aerr;
        logic [31:0] paddr;
        logic        cach, dirty, refd, wr;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];
    int    checks = 0;
    int    errors = 0;
    bit    done = 1'b0;

    function automatic exp_t e_hit(logic [31:0] pa, logic c, logic d, logic r, logic w);
        exp_t e = '0;
        e.hit = 1'b1; e.paddr = pa; e.cach = c; e.dirty = d; e.refd = r; e.wr = w;
        return e;
    endfunction
    function automatic exp_t e_miss();
        exp_t e = '0; e.miss = 1'b1; return e;
    endfunction
    function automatic exp_t e_prot();
        exp_t e = '0; e.prot = 1'b1; return e;
    endfunction
    function automatic exp_t e_aerr();
        exp_t e = '0; e.aerr = 1'b1; return e;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: compare each response against the oldest queued expectation.
    always @(negedge clk) begin
        if (!rst && !done && rsp_valid) begin
            exp_t  act;
            exp_t  e;
            string t;
            act = {rsp_hit, rsp_miss, rsp_prot_fault, rsp_addr_err, rsp_paddr,
                   rsp_cacheable, rsp_dirty, rsp_referenced, rsp_writable};
            if (exp_q.size() == 0) begin
                check(1'b0, "R7 unexpected response", 64'(act), 64'd0);
            end else begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(act == e, t, 64'(act), 64'(e));
            end
        end
    end

    task automatic lookup(input logic [31:0] va, input logic [5:0] asid, input logic st,
                          input logic usr, input exp_t e, input string tag);
        @(negedge clk);
        lk_req = 1'b1; lk_vaddr = va; lk_asid = asid; lk_store = st; lk_user_mode = usr;
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            lk_req = 1'b0; wr_en = 1'b0; inv_en = 1'b0; flush_all = 1'b0;
        end
    endtask

    task automatic set_wr(input logic [5:0] idx, input logic [19:0] vpn, input logic [5:0] asid,
                          input logic [19:0] pfn, input logic d, input logic r, input logic v,
                          input logic w);
        wr_en = 1'b1; wr_idx = idx; wr_vpn = vpn; wr_asid = asid; wr_pfn = pfn;
        wr_dirty = d; wr_ref = r; wr_valid = v; wr_writable = w;
    endtask

    task automatic write_ent(input logic [5:0] idx, input logic [19:0] vpn, input logic [5:0] asid,
                             input logic [19:0] pfn, input logic d, input logic r, input logic v,
                             input logic w);
        @(negedge clk);
        lk_req = 1'b0; inv_en = 1'b0; flush_all = 1'b0;
        set_wr(idx, vpn, asid, pfn, d, r, v, w);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R7 R11: reset state
        check(rsp_valid == 1'b0, "R7 no response in reset", 64'(rsp_valid), 64'd0);
        check(rand_idx == 6'd0, "R11 index zero in reset", 64'(rand_idx), 64'd0);
        @(negedge clk);
        rst = 1'b0;

        // R12 R4: empty store misses
        lookup(32'h0040_0123, 6'd1, 1'b0, 1'b0, e_miss(), "R12 empty store miss");
        lookup(32'hC000_1000, 6'd1, 1'b0, 1'b0, e_miss(), "R4 kernel mapped miss");
        // R1 R2: direct regions, back to back
        lookup(32'h8012_3456, 6'd1, 1'b0, 1'b0, e_hit(32'h0012_3456, 1, 0, 0, 1), "R2 cached direct");
        lookup(32'hA0AB_CDEF, 6'd9, 1'b1, 1'b0, e_hit(32'h00AB_CDEF, 0, 0, 0, 1), "R1 uncached direct");
        // R6: user mode into kernel regions
        lookup(32'h8000_0000, 6'd1, 1'b0, 1'b1, e_aerr(), "R6 user to direct kernel");
        lookup(32'hC000_1000, 6'd1, 1'b1, 1'b1, e_aerr(), "R6 user to mapped kernel");
        idle(1);

        // R8 R3: write then translate
        write_ent(6'd3, 20'h00400, 6'd1, 20'h12345, 1, 1, 1, 1);
        write_ent(6'd10, 20'hC0001, 6'd7, 20'h0ABCD, 0, 0, 1, 0);
        lookup(32'h0040_0ABC, 6'd1, 1'b0, 1'b0, e_hit(32'h1234_5ABC, 1, 1, 1, 1), "R3 user hit");
        lookup(32'h0040_0ABC, 6'd2, 1'b0, 1'b0, e_miss(), "R3 identifier mismatch");
        lookup(32'h0040_1ABC, 6'd1, 1'b0, 1'b0, e_miss(), "R4 page mismatch");
        lookup(32'hC000_1FFF, 6'd7, 1'b0, 1'b0, e_hit(32'h0ABC_DFFF, 1, 0, 0, 0), "R5 load to read-only");
        lookup(32'hC000_1FFF, 6'd7, 1'b1, 1'b0, e_prot(), "R5 store to read-only");
        lookup(32'h0040_0004, 6'd1, 1'b1, 1'b0, e_hit(32'h1234_5004, 1, 1, 1, 1), "R5 store to writable");
        idle(1);

        // R8: entry written with valid clear stays unmatched
        write_ent(6'd12, 20'h00666, 6'd1, 20'h00666, 0, 0, 0, 1);
        lookup(32'h0066_6000, 6'd1, 1'b0, 1'b0, e_miss(), "R8 invalid write");

        // R8: write and lookup in the same cycle
        @(negedge clk);
        set_wr(6'd20, 20'h00777, 6'd1, 20'h00077, 0, 0, 1, 1);
        lk_req = 1'b1; lk_vaddr = 32'h0077_7010; lk_asid = 6'd1; lk_store = 1'b0; lk_user_mode = 1'b0;
        exp_q.push_back(e_miss()); tag_q.push_back("R8 same cycle sees old");
        @(negedge clk);
        wr_en = 1'b0;
        exp_q.push_back(e_hit(32'h0007_7010, 1, 0, 0, 1)); tag_q.push_back("R8 next cycle sees new");
        idle(1);

        // R13: duplicate tags, lowest slot wins
        write_ent(6'd30, 20'h00555, 6'd1, 20'h0AAAA, 0, 0, 1, 1);
        write_ent(6'd5, 20'h00555, 6'd1, 20'h0BBBB, 0, 0, 1, 1);
        lookup(32'h0055_5123, 6'd1, 1'b0, 1'b0, e_hit(32'h0BBB_B123, 1, 0, 0, 1), "R13 lowest slot");
        idle(1);

        // R9: single invalidate
        @(negedge clk);
        inv_en = 1'b1; inv_idx = 6'd5;
        lookup(32'h0055_5123, 6'd1, 1'b0, 1'b0, e_hit(32'h0AAA_A123, 1, 0, 0, 1), "R9 other slot remains");
        inv_en = 1'b0;
        lookup(32'h0040_0ABC, 6'd1, 1'b0, 1'b0, e_hit(32'h1234_5ABC, 1, 1, 1, 1), "R9 unrelated slot kept");
        idle(1);
        // R9: invalidate beats write to the same slot
        @(negedge clk);
        inv_en = 1'b1; inv_idx = 6'd30;
        set_wr(6'd30, 20'h00888, 6'd1, 20'h00888, 0, 0, 1, 1);
        idle(1);
        lookup(32'h0088_8000, 6'd1, 1'b0, 1'b0, e_miss(), "R9 invalidate beats write");
        lookup(32'h0055_5000, 6'd1, 1'b0, 1'b0, e_miss(), "R9 invalidated slot");
        idle(1);

        // R10: flush beats a simultaneous write
        @(negedge clk);
        flush_all = 1'b1;
        set_wr(6'd40, 20'h00999, 6'd3, 20'h00999, 0, 0, 1, 1);
        idle(1);
        lookup(32'h0040_0ABC, 6'd1, 1'b0, 1'b0, e_miss(), "R10 flushed slot 3");
        lookup(32'hC000_1000, 6'd7, 1'b0, 1'b0, e_miss(), "R10 flushed slot 10");
        lookup(32'h0099_9000, 6'd3, 1'b0, 1'b0, e_miss(), "R10 flush beats write");
        lookup(32'h0077_7000, 6'd1, 1'b0, 1'b0, e_miss(), "R10 flushed slot 20");
        idle(3);
        check(exp_q.size() == 0, "R7 all responses seen", 64'(exp_q.size()), 64'd0);

        // R11: replacement index steps and wraps
        begin
            logic [5:0] a;
            @(negedge clk);
            a = rand_idx;
            repeat (5) @(negedge clk);
            check(rand_idx == 6'(a + 6'd5), "R11 index advance", 64'(rand_idx), 64'(6'(a + 6'd5)));
            while (rand_idx != 6'd63) @(negedge clk);
            @(negedge clk);
            check(rand_idx == 6'd0, "R11 index wrap", 64'(rand_idx), 64'd0);
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule